// File: doc/BRIEF.md
# I2C Write Target for an 8-bit I/O Expander

This block lets an I2C controller write an 8-bit I/O expander's setup. It oversamples SCL and SDA with the system clock and finds Start and Stop conditions from the sampled lines. It answers one 7-bit address, which is a fixed four-bit prefix followed by three strap inputs. After a matching write address, the first byte is a command that chooses a register. Every byte after that goes into the chosen register, and a transfer may carry any number of them.

Three registers drive the pins: the output drive value, the input polarity inversion mask and the direction mask. The block pulls SDA low only to acknowledge a byte. It does not handle read transfers and never stretches the clock.

Top module: `i2c_exp_wr_target`

## Requirements
- R1: After a synchronous reset the output register reads 0xFF, the polarity register reads 0x00 and the direction register reads 0xFF, and SDA is released.
- R2: An address byte whose upper seven bits are 0b0011 followed by strap_i[2:0] (MSB first) and whose last bit (read/write) is 0 is acknowledged: sda_low_o is high during the high phase of the ninth SCL clock.
- R3: An address byte that does not match, or whose read/write bit is 1, is not acknowledged. Nothing more is acknowledged or stored until the next Start.
- R4: The byte after a matched address is a command and is acknowledged. Command 0x01 selects the output register, 0x02 the polarity register and 0x03 the direction register.
- R5: Any other command value is acknowledged, and the data bytes that follow it are acknowledged but change no register.
- R6: Every data byte is acknowledged. Any number of data bytes may follow one command, and each one overwrites the same selected register.
- R7: A register takes a data byte no later than the fourth system clock edge after the falling SCL that ends that byte's acknowledge clock, and it changes at no other time.
- R8: A Stop or a repeated Start in the middle of a byte discards the partial byte. A repeated Start begins a new address phase.
- R9: sda_low_o is asserted only in acknowledge slots, never while the controller sends data bits, and changes only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad (wired value) |
| strap_i | input | 3 | Address strap inputs, low three address bits |
| sda_low_o | output | 1 | High to pull SDA low (open-drain enable) |
| out_port_o | output | 8 | Output drive register |
| pol_inv_o | output | 8 | Input polarity inversion register |
| cfg_o | output | 8 | Direction register, 1 = input |

## Verification
The assertions check several rules on every cycle. The acknowledge drive appears only in acknowledge states and switches only while SCL is low. Each register changes only on the cycle after a write pulse aimed at it, a write pulse follows only a data acknowledge, and a Start always returns the control to the address phase. Some behaviour only the bench scenarios can show: address matching against the straps, rejecting a read request, ignoring everything after a mismatch until the next Start, command decoding, long runs of data bytes, and discarding a byte that a Stop or repeated Start cuts short. The bench shows these by comparing the register outputs with its own model on every quiet clock.

// File: rtl/exp_wr_pkg.sv
// Package: shared types and command decoding for the expander write target.
// Assumes bytes are eight bits wide and that commands are whole bytes.
package exp_wr_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned NUM_REGS = 3;

    // Control states of the byte engine.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } wr_state_e;

    // Register selected by the command byte. The codes 1..NUM_REGS index the file.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_OUT  = 2'd1,
        SEL_POL  = 2'd2,
        SEL_CFG  = 2'd3
    } reg_sel_e;

    // Map a command byte onto a register selection.
    function automatic reg_sel_e decode_cmd(input logic [BYTE_W-1:0] cmd);
        reg_sel_e sel;
        case (cmd)
            8'h01:   sel = SEL_OUT;
            8'h02:   sel = SEL_POL;
            8'h03:   sel = SEL_CFG;
            default: sel = SEL_NONE;
        endcase
        return sel;
    endfunction

    // True for the states in which the target owns the acknowledge slot.
    function automatic logic is_ack_state(input wr_state_e st);
        return (st == ST_ADDR_ACK) || (st == ST_CMD_ACK) || (st == ST_DATA_ACK);
    endfunction

endpackage

// File: rtl/exp_bus_sampler.sv
// Module: synchronises SCL and SDA into the system clock domain and flags
// SCL edges and Start/Stop conditions.
// Assumes the system clock is at least several times faster than SCL, so that
// every SCL phase lasts for several samples. Event flags are one-cycle pulses.
module exp_bus_sampler #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    // Build the synchroniser chain, one flop per stage for each line.
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            // First stage: capture the raw pad values.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else begin
                    scl_pipe[g] <= scl_i;
                    sda_pipe[g] <= sda_i;
                end
            end
        end else begin : g_next
            // Later stages: pass the value along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else begin
                    scl_pipe[g] <= scl_pipe[g-1];
                    sda_pipe[g] <= sda_pipe[g-1];
                end
            end
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Keep the previous synchronised values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    // Derive the SCL edges and the SDA transitions made while SCL is high.
    always_comb begin
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start_evt = scl_s & scl_prev & ~sda_s & sda_prev;
        stop_evt  = scl_s & scl_prev & sda_s & ~sda_prev;
    end

endmodule

// File: rtl/exp_wr_fsm.sv
// Module: byte engine of the write target. It shifts in bits on SCL rising
// edges, checks the address, latches the command and raises a one-cycle write
// pulse when a data byte's acknowledge clock ends.
// Assumes the events come from exp_bus_sampler and that the address prefix
// plus the straps make up the upper bits of the address byte (7 bits).
module exp_wr_fsm
    import exp_wr_pkg::*;
#(
    parameter logic [3:0]  ADDR_PREFIX = 4'b0011,
    parameter int unsigned STRAP_W     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_evt,
    input  logic                stop_evt,
    input  logic                sda_s,
    input  logic [STRAP_W-1:0]  strap_i,
    output logic                sda_low_o,
    output logic                wr_en_o,
    output reg_sel_e            wr_sel_o,
    output logic [BYTE_W-1:0]   wr_data_o,
    output wr_state_e           state_o
);

    localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
    localparam int unsigned ADDR_W = $bits(ADDR_PREFIX) + STRAP_W;

    wr_state_e          state_q;
    logic [BYTE_W-1:0]  shreg_q;
    logic [CNT_W-1:0]   cnt_q;
    reg_sel_e           sel_q;
    logic [BYTE_W-1:0]  data_q;
    logic               drive_q;
    logic               wr_q;
    logic               receiving;
    logic               byte_full;
    logic               byte_done;
    logic               addr_hit;

    // Decode the engine's current situation.
    always_comb begin
        receiving = (state_q == ST_ADDR) || (state_q == ST_CMD) || (state_q == ST_DATA);
        byte_full = (cnt_q == CNT_W'(BYTE_W));
        byte_done = receiving && byte_full && scl_fall;
        addr_hit  = (shreg_q[BYTE_W-1:BYTE_W-ADDR_W] == {ADDR_PREFIX, strap_i})
                    && (shreg_q[0] == 1'b0);
    end

    // Shift received bits and count them within the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (start_evt || stop_evt) begin
            cnt_q <= '0;
        end else if (receiving && scl_rise && !byte_full) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
            cnt_q   <= cnt_q + 1'b1;
        end else if (byte_done) begin
            cnt_q <= '0;
        end
    end

    // Sequence the transfer: address, command, data and their acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= SEL_NONE;
            data_q  <= '0;
            drive_q <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            wr_q <= 1'b0;
            if (start_evt) begin
                state_q <= ST_ADDR;
                drive_q <= 1'b0;
            end else if (stop_evt) begin
                state_q <= ST_IDLE;
                drive_q <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR: begin
                        if (byte_done) begin
                            if (addr_hit) begin
                                drive_q <= 1'b1;
                                state_q <= ST_ADDR_ACK;
                            end else begin
                                state_q <= ST_SKIP;
                            end
                        end
                    end
                    ST_CMD: begin
                        if (byte_done) begin
                            sel_q   <= decode_cmd(shreg_q);
                            drive_q <= 1'b1;
                            state_q <= ST_CMD_ACK;
                        end
                    end
                    ST_DATA: begin
                        if (byte_done) begin
                            data_q  <= shreg_q;
                            drive_q <= 1'b1;
                            state_q <= ST_DATA_ACK;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            drive_q <= 1'b0;
                            state_q <= ST_CMD;
                        end
                    end
                    ST_CMD_ACK: begin
                        if (scl_fall) begin
                            drive_q <= 1'b0;
                            state_q <= ST_DATA;
                        end
                    end
                    ST_DATA_ACK: begin
                        if (scl_fall) begin
                            drive_q <= 1'b0;
                            wr_q    <= 1'b1;
                            state_q <= ST_DATA;
                        end
                    end
                    default: begin
                        drive_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign sda_low_o = drive_q;
    assign wr_en_o   = wr_q;
    assign wr_sel_o  = sel_q;
    assign wr_data_o = data_q;
    assign state_o   = state_q;

endmodule

// File: rtl/exp_regfile.sv
// Module: the expander's control registers. There is one register per
// selection code, each loaded by a write pulse that carries its code.
// Assumes wr_en_i is a single-cycle pulse. SEL_NONE loads nothing.
module exp_regfile
    import exp_wr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] OUT_RST = 8'hFF,
    parameter logic [BYTE_W-1:0] POL_RST = 8'h00,
    parameter logic [BYTE_W-1:0] CFG_RST = 8'hFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  reg_sel_e            wr_sel_i,
    input  logic [BYTE_W-1:0]   wr_data_i,
    output logic [BYTE_W-1:0]   out_o,
    output logic [BYTE_W-1:0]   pol_o,
    output logic [BYTE_W-1:0]   cfg_o
);

    localparam logic [NUM_REGS*BYTE_W-1:0] RST_VALS = {CFG_RST, POL_RST, OUT_RST};

    logic [NUM_REGS*BYTE_W-1:0] regs_flat;

    // One register per selection code.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [1:0] CODE = 2'(g + 1);
        logic [BYTE_W-1:0] q;

        // Load this register when a write pulse carries its code.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= RST_VALS[g*BYTE_W +: BYTE_W];
            end else if (wr_en_i && (wr_sel_i == reg_sel_e'(CODE))) begin
                q <= wr_data_i;
            end
        end

        assign regs_flat[g*BYTE_W +: BYTE_W] = q;
    end

    assign out_o = regs_flat[0*BYTE_W +: BYTE_W];
    assign pol_o = regs_flat[1*BYTE_W +: BYTE_W];
    assign cfg_o = regs_flat[2*BYTE_W +: BYTE_W];

endmodule

// File: rtl/i2c_exp_wr_target.sv
// Module: top of the I2C write target for the I/O expander. It joins the line
// sampler, the byte engine and the register file.
// Assumes clk is much faster than SCL and that sda_i is the wired line value,
// including this block's own pull-down.
module i2c_exp_wr_target
    import exp_wr_pkg::*;
#(
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [3:0]        ADDR_PREFIX = 4'b0011,
    parameter int unsigned       STRAP_W     = 3,
    parameter logic [BYTE_W-1:0] OUT_RST     = 8'hFF,
    parameter logic [BYTE_W-1:0] POL_RST     = 8'h00,
    parameter logic [BYTE_W-1:0] CFG_RST     = 8'hFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [STRAP_W-1:0]  strap_i,
    output logic                sda_low_o,
    output logic [BYTE_W-1:0]   out_port_o,
    output logic [BYTE_W-1:0]   pol_inv_o,
    output logic [BYTE_W-1:0]   cfg_o
);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic              wr_en;
    reg_sel_e          wr_sel;
    logic [BYTE_W-1:0] wr_data;
    wr_state_e         fsm_state;

    exp_bus_sampler #(
        .STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    exp_wr_fsm #(
        .ADDR_PREFIX (ADDR_PREFIX),
        .STRAP_W     (STRAP_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_s     (sda_s),
        .strap_i   (strap_i),
        .sda_low_o (sda_low_o),
        .wr_en_o   (wr_en),
        .wr_sel_o  (wr_sel),
        .wr_data_o (wr_data),
        .state_o   (fsm_state)
    );

    exp_regfile #(
        .OUT_RST (OUT_RST),
        .POL_RST (POL_RST),
        .CFG_RST (CFG_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .out_o     (out_port_o),
        .pol_o     (pol_inv_o),
        .cfg_o     (cfg_o)
    );

endmodule

// File: rtl/i2c_exp_wr_checker.sv
// Module: checker holding the clocked properties of the write target. It is
// bound to the top module and only observes, driving nothing.
module i2c_exp_wr_checker
    import exp_wr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] OUT_RST = 8'hFF,
    parameter logic [BYTE_W-1:0] POL_RST = 8'h00,
    parameter logic [BYTE_W-1:0] CFG_RST = 8'hFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_evt,
    input wr_state_e         state,
    input logic              sda_low,
    input logic              wr_en,
    input reg_sel_e          wr_sel,
    input logic [BYTE_W-1:0] out_port,
    input logic [BYTE_W-1:0] pol_inv,
    input logic [BYTE_W-1:0] cfg
);

    // R1: the first cycle out of reset shows the reset values.
    a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (out_port == OUT_RST) && (pol_inv == POL_RST) && (cfg == CFG_RST));

    // R9: the pull-down is only active in an acknowledge state.
    a_r9_drive_in_ack_only: assert property (@(posedge clk) disable iff (!rst_n)
        sda_low |-> is_ack_state(state));

    // R9: the pull-down changes only while the sampled SCL is low.
    a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low) |-> !scl_s);

    // R3: a skipped transfer never pulls SDA low.
    a_r3_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_low);

    // R8: a Start always leads to the address phase.
    a_r8_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_ADDR));

    // R6: a write pulse only follows a data acknowledge.
    a_r6_write_after_data_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(state == ST_DATA_ACK));

    // R7: the output register changes only after a write aimed at it.
    a_r7_out_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_port) |-> $past(wr_en && (wr_sel == SEL_OUT)));

    // R4: the polarity register changes only after a write aimed at it.
    a_r4_pol_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pol_inv) |-> $past(wr_en && (wr_sel == SEL_POL)));

    // R4: the direction register changes only after a write aimed at it.
    a_r4_cfg_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> $past(wr_en && (wr_sel == SEL_CFG)));

endmodule

bind i2c_exp_wr_target i2c_exp_wr_checker #(
    .OUT_RST (OUT_RST),
    .POL_RST (POL_RST),
    .CFG_RST (CFG_RST)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_evt (start_evt),
    .state     (fsm_state),
    .sda_low   (sda_low_o),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .out_port  (out_port_o),
    .pol_inv   (pol_inv_o),
    .cfg       (cfg_o)
);

// File: tb/tb_i2c_exp_wr_target.sv
// Bench: acts as an I2C controller and keeps a behavioural model of the three
// registers. The model is compared with the outputs on every clock once the
// bus has been quiet for the allowed latency.
module tb_i2c_exp_wr_target;

    localparam int Q      = 8;   // system clocks per quarter SCL period
    localparam int SETTLE = 6;   // clocks allowed for sync plus register update

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_low;
    logic       sda_line;
    logic [7:0] out_port, pol_inv, cfg;

    logic [7:0] m_out = 8'hFF, m_pol = 8'h00, m_cfg = 8'hFF;
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_drv = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    assign sda_line = sda_m & ~sda_low;

    i2c_exp_wr_target dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .sda_low_o  (sda_low),
        .out_port_o (out_port),
        .pol_inv_o  (pol_inv),
        .cfg_o      (cfg)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // R7: per-clock comparison of the registers with the model.
    always @(negedge clk) begin
        if (rst_n && !done && (cyc - last_drv >= SETTLE)) begin
            chk("R7 out_port", out_port, m_out);
            chk("R7 pol_inv", pol_inv, m_pol);
            chk("R7 cfg", cfg, m_cfg);
        end
    end

    task automatic set_bus(input logic s, input logic d);
        @(posedge clk);
        #2;
        scl_m = s;
        sda_m = d;
        last_drv = cyc;
    endtask

    task automatic pause();
        repeat (Q) @(posedge clk);
    endtask

    task automatic i2c_start();
        set_bus(1'b0, 1'b1); pause();
        set_bus(1'b1, 1'b1); pause();
        set_bus(1'b1, 1'b0); pause();
        set_bus(1'b0, 1'b0); pause();
    endtask

    task automatic i2c_stop();
        set_bus(1'b0, 1'b0); pause();
        set_bus(1'b1, 1'b0); pause();
        set_bus(1'b1, 1'b1); pause();
    endtask

    // R9: no pull-down while a data bit is on the bus.
    task automatic send_bit(input logic b);
        set_bus(1'b0, b); pause();
        set_bus(1'b1, b); pause();
        chk("R9 no drive in data bit", {7'd0, sda_low}, 8'h00);
        pause();
        set_bus(1'b0, b); pause();
    endtask

    // upd: 0 none, 1 output, 2 polarity, 3 direction (model update at ack end)
    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input int upd,
                             input string req);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        set_bus(1'b0, 1'b1); pause();
        set_bus(1'b1, 1'b1); pause();
        chk(req, {7'd0, sda_low}, {7'd0, exp_ack});
        pause();
        set_bus(1'b0, 1'b1);
        case (upd)
            1: m_out = b;
            2: m_pol = b;
            3: m_cfg = b;
            default: ;
        endcase
        pause();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk("R1 out reset", out_port, 8'hFF);
        chk("R1 pol reset", pol_inv, 8'h00);
        chk("R1 cfg reset", cfg, 8'hFF);
        chk("R1 sda released", {7'd0, sda_low}, 8'h00);

        // R2, R4: output register write
        i2c_start();
        send_byte(8'h3A, 1'b1, 0, "R2 address ack");
        send_byte(8'h01, 1'b1, 0, "R4 command ack");
        send_byte(8'h5A, 1'b1, 1, "R6 data ack");
        i2c_stop();
        chk("R4 output written", out_port, 8'h5A);

        // R6: several bytes to the direction register
        i2c_start();
        send_byte(8'h3A, 1'b1, 0, "R2 address ack");
        send_byte(8'h03, 1'b1, 0, "R4 command ack");
        send_byte(8'h0F, 1'b1, 3, "R6 data ack 1");
        send_byte(8'hF0, 1'b1, 3, "R6 data ack 2");
        send_byte(8'h33, 1'b1, 3, "R6 data ack 3");
        send_byte(8'h81, 1'b1, 3, "R6 data ack 4");
        i2c_stop();
        chk("R6 last byte kept", cfg, 8'h81);
        chk("R6 output untouched", out_port, 8'h5A);

        // R4: polarity register
        i2c_start();
        send_byte(8'h3A, 1'b1, 0, "R2 address ack");
        send_byte(8'h02, 1'b1, 0, "R4 command ack");
        send_byte(8'hC3, 1'b1, 2, "R6 data ack");
        i2c_stop();
        chk("R4 polarity written", pol_inv, 8'hC3);

        // R5: unknown commands discard data
        i2c_start();
        send_byte(8'h3A, 1'b1, 0, "R2 address ack");
        send_byte(8'h00, 1'b1, 0, "R5 command 0x00 ack");
        send_byte(8'h12, 1'b1, 0, "R5 data ack");
        send_byte(8'h34, 1'b1, 0, "R5 data ack");
        i2c_start();
        send_byte(8'h3A, 1'b1, 0, "R2 address ack");
        send_byte(8'h07, 1'b1, 0, "R5 command 0x07 ack");
        send_byte(8'hEE, 1'b1, 0, "R5 data ack");
        i2c_stop();
        chk("R5 output unchanged", out_port, 8'h5A);
        chk("R5 polarity unchanged", pol_inv, 8'hC3);
        chk("R5 direction unchanged", cfg, 8'h81);

        // R3: wrong address, then read request
        i2c_start();
        send_byte(8'h38, 1'b0, 0, "R3 mismatch no ack");
        send_byte(8'h01, 1'b0, 0, "R3 ignored byte");
        send_byte(8'h00, 1'b0, 0, "R3 ignored byte");
        i2c_stop();
        i2c_start();
        send_byte(8'h3B, 1'b0, 0, "R3 read not acked");
        send_byte(8'h01, 1'b0, 0, "R3 ignored byte");
        i2c_stop();
        chk("R3 output unchanged", out_port, 8'h5A);

        // R3: ignoring lasts until a new Start, which is then honoured
        i2c_start();
        send_byte(8'h38, 1'b0, 0, "R3 mismatch no ack");
        send_byte(8'h77, 1'b0, 0, "R3 ignored byte");
        i2c_start();
        send_byte(8'h3A, 1'b1, 0, "R3 new start address ack");
        send_byte(8'h01, 1'b1, 0, "R4 command ack");
        send_byte(8'h66, 1'b1, 1, "R6 data ack");
        i2c_stop();
        chk("R3 write after restart", out_port, 8'h66);

        // R8: partial byte cut by Stop
        i2c_start();
        send_byte(8'h3A, 1'b1, 0, "R2 address ack");
        send_byte(8'h01, 1'b1, 0, "R4 command ack");
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        i2c_stop();
        chk("R8 stop discards partial", out_port, 8'h66);

        // R8: partial byte cut by repeated Start
        i2c_start();
        send_byte(8'h3A, 1'b1, 0, "R2 address ack");
        send_byte(8'h02, 1'b1, 0, "R4 command ack");
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        i2c_start();
        send_byte(8'h3A, 1'b1, 0, "R8 restart address ack");
        send_byte(8'h01, 1'b1, 0, "R4 command ack");
        send_byte(8'h99, 1'b1, 1, "R6 data ack");
        i2c_stop();
        chk("R8 restart write", out_port, 8'h99);
        chk("R8 partial polarity dropped", pol_inv, 8'hC3);

        // R2: address follows the straps
        strap = 3'b010;
        repeat (4) @(posedge clk);
        i2c_start();
        send_byte(8'h3A, 1'b0, 0, "R2 old strap address rejected");
        i2c_stop();
        i2c_start();
        send_byte(8'h34, 1'b1, 0, "R2 new strap address ack");
        send_byte(8'h03, 1'b1, 0, "R4 command ack");
        send_byte(8'h00, 1'b1, 3, "R6 data ack");
        i2c_stop();
        chk("R2 direction written", cfg, 8'h00);

        repeat (10) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule